// File: doc/BRIEF.md
# Max-Metric LLR Accumulator

This block sits at the end of a stochastic soft-output detector. In each cycle it receives, from several parallel samplers, the pair of candidate metrics for one bit position: one metric for the bit forced to 0 and one for the bit forced to 1. Each metric comes with its own validity token. The block first reduces the valid inputs to a local maximum for each bit value. It then merges that maximum into one of two register files, one per bit value. Each file holds a running-maximum entry and a validity flag for every bit position of the symbol vector.

When all samples for a symbol vector have been drawn, the consumer reads the positions back one at a time and supplies the prior LLR with each request. One cycle later the block returns the saturated extrinsic LLR: the bit-0 maximum minus the bit-1 maximum minus the prior. A start-of-vector pulse clears every stored flag, so the files never need a sentinel value for an empty entry. Inputs tagged with sample index 0 belong to the burn-in draw and are left out of the search.

Top module: `llr_max_acc`

## Requirements
- R1: After reset `llr_vld_o` and `llr_o` are 0, and every position reads back as having no valid entry for either bit value.
- R2: A cycle with `sov_i` high clears the valid flags of all positions in both files. A metric accepted in that same cycle is stored into the cleared state, so only that metric survives.
- R3: For each bit value separately, only metrics whose token bit in `vld0_i`/`vld1_i` is 1 take part. The signed largest of them is the local maximum, and a bit value with no valid token leaves its file unchanged.
- R4: When `samp_idx_i` is 0, no metric is stored and no flag changes in either file.
- R5: A local maximum replaces the stored entry for `bit_idx_i` when that entry's flag is clear or when the new value is strictly larger as a signed number. Otherwise the entry keeps its value. Other positions are never modified.
- R6: For a position where both entries are valid, the result is (max0 − max1 − 2·prior) shifted right arithmetically by one bit. Metrics carry 5 fraction bits, while the prior and the output carry 4, so the shift rounds toward minus infinity.
- R7: The result of R6 is clamped to the signed 12-bit range [−2048, 2047].
- R8: If only the bit-0 entry is empty the output is −2048. If only the bit-1 entry is empty it is 2047. If both are empty it is 0 and the prior has no effect.
- R9: `llr_vld_o` is high in exactly the cycle after a cycle with `rd_en_i` high, and `llr_o` changes only then. A read sees the files as they were before any write at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sov_i | input | 1 | Start of symbol vector, clears all valid flags |
| samp_idx_i | input | 4 | Sample index of the current inputs; 0 means excluded |
| bit_idx_i | input | 5 | Bit position the current metrics belong to |
| vld0_i | input | 4 | Token per sampler for the bit-0 metric |
| met0_i | input | 96 | Bit-0 metrics, 24-bit signed each, sampler i at bits [24i+23:24i] |
| vld1_i | input | 4 | Token per sampler for the bit-1 metric |
| met1_i | input | 96 | Bit-1 metrics, same packing as met0_i |
| rd_en_i | input | 1 | Request one extrinsic LLR |
| rd_idx_i | input | 5 | Bit position to read |
| rd_prior_i | input | 9 | Signed prior LLR for that position, 4 fraction bits |
| llr_o | output | 12 | Signed saturated extrinsic LLR, 4 fraction bits |
| llr_vld_o | output | 1 | `llr_o` was updated in this cycle |

## Verification
The checker takes it for granted that `bit_idx_i` and `rd_idx_i` stay below the number of positions. An out-of-range read would index past the flag vector, and the zero-result property guards on the index only for that reason. The bench drives every index from a small set of in-range positions and holds all inputs inactive except during the single cycle a task applies them. It also relies on the prior being narrow enough that its doubled value cannot overflow the widened subtraction. The bench keeps priors within a few hundred counts and places metrics well inside the 24-bit range, even where it forces saturation.

// File: rtl/llr_acc_pkg.sv
package llr_acc_pkg;

  // Which of the two stored maxima are present for a position
  typedef enum logic [1:0] {
    LLR_EMPTY  = 2'b00,
    LLR_ONLY1  = 2'b01,
    LLR_ONLY0  = 2'b10,
    LLR_BOTH   = 2'b11
  } llr_case_e;

  function automatic llr_case_e llr_classify(input logic tok0, input logic tok1);
    return llr_case_e'({tok0, tok1});
  endfunction

endpackage

// File: rtl/llr_cs_tree.sv
// Compare-select over all samplers: signed maximum of the valid inputs only.
module llr_cs_tree #(
  parameter int NUM_SAMP = 4,
  parameter int MET_W    = 24
) (
  input  logic [NUM_SAMP-1:0]       vld_i,
  input  logic [NUM_SAMP*MET_W-1:0] met_i,
  output logic                      vld_o,
  output logic signed [MET_W-1:0]   max_o
);

  logic signed [MET_W-1:0] cand;

  always_comb begin
    vld_o = 1'b0;
    max_o = '0;
    cand  = '0;
    for (int i = 0; i < NUM_SAMP; i++) begin
      cand = $signed(met_i[i*MET_W +: MET_W]);
      if (vld_i[i] && (!vld_o || cand > max_o)) begin
        max_o = cand;
        vld_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/llr_max_rf.sv
// Running-maximum register file with one validity flag per entry.
module llr_max_rf #(
  parameter int NUM_BITS = 24,
  parameter int MET_W    = 24,
  parameter int IDX_W    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic signed [MET_W-1:0] wval_i,
  input  logic [IDX_W-1:0]        ridx_i,
  output logic signed [MET_W-1:0] rval_o,
  output logic                    rtok_o,
  output logic [NUM_BITS-1:0]     tok_o
);

  logic signed [MET_W-1:0] ent_q [NUM_BITS];
  logic [NUM_BITS-1:0]     tok_q;
  logic [NUM_BITS-1:0]     tok_d;
  logic [NUM_BITS-1:0]     take;

  for (genvar e = 0; e < NUM_BITS; e++) begin : g_ent
    assign take[e]  = wr_i && (int'(widx_i) == e) &&
                      (clr_i || !tok_q[e] || (wval_i > ent_q[e]));
    assign tok_d[e] = take[e] | (tok_q[e] & ~clr_i);

    always_ff @(posedge clk) begin
      if (take[e]) begin
        ent_q[e] <= wval_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else begin
      tok_q <= tok_d;
    end
  end

  logic in_range;
  assign in_range = int'(ridx_i) < NUM_BITS;
  assign rtok_o   = in_range ? tok_q[ridx_i] : 1'b0;
  assign rval_o   = in_range ? ent_q[ridx_i] : '0;
  assign tok_o    = tok_q;

endmodule

// File: rtl/llr_out_stage.sv
// Extrinsic LLR: subtract, rescale, saturate, register.
module llr_out_stage
  import llr_acc_pkg::*;
#(
  parameter int MET_W  = 24,
  parameter int PRI_W  = 9,
  parameter int OUT_W  = 12,
  parameter int SHIFT  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_i,
  input  logic signed [MET_W-1:0] v0_i,
  input  logic                    t0_i,
  input  logic signed [MET_W-1:0] v1_i,
  input  logic                    t1_i,
  input  logic signed [PRI_W-1:0] prior_i,
  output logic signed [OUT_W-1:0] llr_o,
  output logic                    vld_o
);

  localparam int DW = MET_W + 3;
  localparam logic signed [DW-1:0] POS_L = DW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [DW-1:0] NEG_L = -POS_L - DW'(1);

  logic signed [DW-1:0]    diff;
  logic signed [DW-1:0]    scaled;
  logic signed [OUT_W-1:0] sat;
  logic signed [OUT_W-1:0] llr_d;

  always_comb begin
    diff   = DW'(v0_i) - DW'(v1_i) - (DW'(prior_i) <<< SHIFT);
    scaled = diff >>> SHIFT;
    if (scaled > POS_L) begin
      sat = POS_L[OUT_W-1:0];
    end else if (scaled < NEG_L) begin
      sat = NEG_L[OUT_W-1:0];
    end else begin
      sat = scaled[OUT_W-1:0];
    end
    unique case (llr_classify(t0_i, t1_i))
      LLR_BOTH:  llr_d = sat;
      LLR_ONLY0: llr_d = POS_L[OUT_W-1:0];
      LLR_ONLY1: llr_d = NEG_L[OUT_W-1:0];
      default:   llr_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      llr_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= rd_i;
      if (rd_i) begin
        llr_o <= llr_d;
      end
    end
  end

endmodule

// File: rtl/llr_max_acc.sv
module llr_max_acc #(
  parameter int NUM_SAMP   = 4,
  parameter int NUM_BITS   = 24,
  parameter int MET_W      = 24,
  parameter int MET_FRAC   = 5,
  parameter int PRI_W      = 9,
  parameter int OUT_W      = 12,
  parameter int OUT_FRAC   = 4,
  parameter int SAMP_IDX_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sov_i,
  input  logic [SAMP_IDX_W-1:0]        samp_idx_i,
  input  logic [$clog2(NUM_BITS)-1:0]  bit_idx_i,
  input  logic [NUM_SAMP-1:0]          vld0_i,
  input  logic [NUM_SAMP*MET_W-1:0]    met0_i,
  input  logic [NUM_SAMP-1:0]          vld1_i,
  input  logic [NUM_SAMP*MET_W-1:0]    met1_i,
  input  logic                         rd_en_i,
  input  logic [$clog2(NUM_BITS)-1:0]  rd_idx_i,
  input  logic signed [PRI_W-1:0]      rd_prior_i,
  output logic signed [OUT_W-1:0]      llr_o,
  output logic                         llr_vld_o
);

  localparam int BIT_IDX_W = $clog2(NUM_BITS);
  localparam int SHIFT     = MET_FRAC - OUT_FRAC;

  logic [1:0][NUM_SAMP-1:0]       vld_all;
  logic [1:0][NUM_SAMP*MET_W-1:0] met_all;
  logic [1:0]                     lvld;
  logic signed [MET_W-1:0]        lmax [2];
  logic signed [MET_W-1:0]        rval [2];
  logic [1:0]                     rtok;
  logic [1:0][NUM_BITS-1:0]       tok_all;
  logic                           not_burn;

  assign vld_all  = {vld1_i, vld0_i};
  assign met_all  = {met1_i, met0_i};
  assign not_burn = (samp_idx_i != '0);

  for (genvar g = 0; g < 2; g++) begin : g_val
    llr_cs_tree #(
      .NUM_SAMP (NUM_SAMP),
      .MET_W    (MET_W)
    ) u_cs (
      .vld_i (vld_all[g]),
      .met_i (met_all[g]),
      .vld_o (lvld[g]),
      .max_o (lmax[g])
    );

    llr_max_rf #(
      .NUM_BITS (NUM_BITS),
      .MET_W    (MET_W),
      .IDX_W    (BIT_IDX_W)
    ) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (sov_i),
      .wr_i   (lvld[g] & not_burn),
      .widx_i (bit_idx_i),
      .wval_i (lmax[g]),
      .ridx_i (rd_idx_i),
      .rval_o (rval[g]),
      .rtok_o (rtok[g]),
      .tok_o  (tok_all[g])
    );
  end

  llr_out_stage #(
    .MET_W (MET_W),
    .PRI_W (PRI_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_i    (rd_en_i),
    .v0_i    (rval[0]),
    .t0_i    (rtok[0]),
    .v1_i    (rval[1]),
    .t1_i    (rtok[1]),
    .prior_i (rd_prior_i),
    .llr_o   (llr_o),
    .vld_o   (llr_vld_o)
  );

endmodule

// File: rtl/llr_max_acc_chk.sv
module llr_max_acc_chk #(
  parameter int NB    = 24,
  parameter int IW    = 5,
  parameter int SW    = 4,
  parameter int OW    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sov_i,
  input logic [SW-1:0]        samp_idx_i,
  input logic                 rd_en_i,
  input logic [IW-1:0]        rd_idx_i,
  input logic signed [OW-1:0] llr_o,
  input logic                 llr_vld_o,
  input logic [NB-1:0]        tok0,
  input logic [NB-1:0]        tok1
);

  // R2: after a start pulse at most the one same-cycle write remains flagged
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sov_i |=> ($countones(tok0) <= 1 && $countones(tok1) <= 1));

  // R4: burn-in sample leaves every flag alone
  p_burn_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_idx_i == '0 && !sov_i) |=> ($stable(tok0) && $stable(tok1)));

  // R5: without a start pulse flags never drop and at most one rises
  p_flags_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sov_i |=> (((tok0 & $past(tok0)) == $past(tok0)) &&
                ((tok1 & $past(tok1)) == $past(tok1)) &&
                $countones(tok0 ^ $past(tok0)) <= 1 &&
                $countones(tok1 ^ $past(tok1)) <= 1));

  // R8: reading a position with no entries returns zero
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && int'(rd_idx_i) < NB && !tok0[rd_idx_i] && !tok1[rd_idx_i])
      |=> (llr_o == '0));

  // R9: one-cycle read latency, output held between reads
  p_rd_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> llr_vld_o);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (!llr_vld_o && $stable(llr_o)));

endmodule

bind llr_max_acc llr_max_acc_chk #(
  .NB (NUM_BITS),
  .IW (BIT_IDX_W),
  .SW (SAMP_IDX_W),
  .OW (OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sov_i      (sov_i),
  .samp_idx_i (samp_idx_i),
  .rd_en_i    (rd_en_i),
  .rd_idx_i   (rd_idx_i),
  .llr_o      (llr_o),
  .llr_vld_o  (llr_vld_o),
  .tok0       (tok_all[0]),
  .tok1       (tok_all[1])
);

// File: tb/llr_max_acc_test.sv
module llr_max_acc_test;

  localparam int NS = 4;
  localparam int NB = 24;
  localparam int MW = 24;
  localparam int PW = 9;
  localparam int OW = 12;
  localparam int IW = 5;
  localparam int SW = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    sov_i;
  logic [SW-1:0]           samp_idx_i;
  logic [IW-1:0]           bit_idx_i;
  logic [NS-1:0]           vld0_i;
  logic [NS*MW-1:0]        met0_i;
  logic [NS-1:0]           vld1_i;
  logic [NS*MW-1:0]        met1_i;
  logic                    rd_en_i;
  logic [IW-1:0]           rd_idx_i;
  logic signed [PW-1:0]    rd_prior_i;
  logic signed [OW-1:0]    llr_o;
  logic                    llr_vld_o;

  llr_max_acc uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sov_i      (sov_i),
    .samp_idx_i (samp_idx_i),
    .bit_idx_i  (bit_idx_i),
    .vld0_i     (vld0_i),
    .met0_i     (met0_i),
    .vld1_i     (vld1_i),
    .met1_i     (met1_i),
    .rd_en_i    (rd_en_i),
    .rd_idx_i   (rd_idx_i),
    .rd_prior_i (rd_prior_i),
    .llr_o      (llr_o),
    .llr_vld_o  (llr_vld_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int     total = 0;
  int     bad   = 0;
  bit     done  = 0;
  longint mm [2][NB];
  bit     mt [2][NB];
  longint pa [NS];
  longint pb [NS];

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_llr(input int idx, input longint pr);
    longint d;
    if (!mt[0][idx] && !mt[1][idx]) return 0;
    if (!mt[0][idx]) return -2048;
    if (!mt[1][idx]) return 2047;
    d = (mm[0][idx] - mm[1][idx] - 2 * pr) >>> 1;
    if (d > 2047) return 2047;
    if (d < -2048) return -2048;
    return d;
  endfunction

  task automatic model_upd(input bit sov, input int samp, input int bidx,
                           input logic [NS-1:0] v0, input logic [NS-1:0] v1);
    if (sov) begin
      for (int g = 0; g < 2; g++)
        for (int e = 0; e < NB; e++) mt[g][e] = 0;
    end
    if (samp != 0) begin
      for (int g = 0; g < 2; g++) begin
        bit     any = 0;
        longint lm  = 0;
        for (int i = 0; i < NS; i++) begin
          bit     v = (g == 0) ? v0[i] : v1[i];
          longint m = (g == 0) ? pa[i] : pb[i];
          if (v && (!any || m > lm)) begin
            lm  = m;
            any = 1;
          end
        end
        if (any && (!mt[g][bidx] || lm > mm[g][bidx])) begin
          mm[g][bidx] = lm;
          mt[g][bidx] = 1;
        end
      end
    end
  endtask

  task automatic apply_in(input bit sov, input int samp, input int bidx,
                          input logic [NS-1:0] v0, input logic [NS-1:0] v1);
    sov_i      = sov;
    samp_idx_i = SW'(samp);
    bit_idx_i  = IW'(bidx);
    vld0_i     = v0;
    vld1_i     = v1;
    for (int i = 0; i < NS; i++) begin
      met0_i[i*MW +: MW] = MW'(pa[i]);
      met1_i[i*MW +: MW] = MW'(pb[i]);
    end
    model_upd(sov, samp, bidx, v0, v1);
  endtask

  task automatic idle_in();
    sov_i  = 1'b0;
    vld0_i = '0;
    vld1_i = '0;
  endtask

  task automatic push(input bit sov, input int samp, input int bidx,
                      input logic [NS-1:0] v0, input logic [NS-1:0] v1);
    @(negedge clk);
    apply_in(sov, samp, bidx, v0, v1);
    @(negedge clk);
    idle_in();
  endtask

  task automatic rd(input int idx, input longint pr, input string req);
    longint e;
    @(negedge clk);
    e          = exp_llr(idx, pr);
    rd_en_i    = 1'b1;
    rd_idx_i   = IW'(idx);
    rd_prior_i = PW'(pr);
    @(negedge clk);
    rd_en_i    = 1'b0;
    chk({req, " vld"}, longint'(llr_vld_o), 1);
    chk(req, longint'(llr_o), e);
  endtask

  // R1
  task automatic t_reset();
    chk("R1 vld after reset", longint'(llr_vld_o), 0);
    chk("R1 llr after reset", longint'(llr_o), 0);
    rd(0, 37, "R1 empty pos 0");
    rd(23, -50, "R1 empty pos 23");
  endtask

  // R3, R6
  task automatic t_basic();
    pa = '{1000, -200, 3000, 50};
    pb = '{-400, 700, 120, 10};
    push(1, 1, 3, 4'b1111, 4'b1111);
    rd(3, 5, "R6 basic pos 3");
    rd(3, -100, "R6 negative prior");
    pa = '{-10, -33, -7, -900};
    pb = '{-1, -5, -2, -3};
    push(0, 2, 4, 4'b1111, 4'b1111);
    rd(4, 0, "R6 odd difference floors");
  endtask

  // R3
  task automatic t_tokens();
    pa = '{900000, 250, 900000, 900000};
    pb = '{900000, 900000, 900000, -60};
    push(0, 1, 5, 4'b0010, 4'b1000);
    rd(5, 3, "R3 invalid samplers ignored");
    pa = '{5000, 5000, 5000, 5000};
    pb = '{-7000, 0, 0, 0};
    push(0, 3, 5, 4'b0000, 4'b0001);
    rd(5, 3, "R3 empty token leaves file");
  endtask

  // R4
  task automatic t_burn();
    pa = '{700000, 700000, 700000, 700000};
    pb = '{-700000, -700000, -700000, -700000};
    push(0, 0, 3, 4'b1111, 4'b1111);
    rd(3, 5, "R4 sample 0 ignored");
    push(0, 0, 9, 4'b1111, 4'b1111);
    rd(9, 0, "R4 sample 0 never sets flag");
  endtask

  // R5
  task automatic t_running();
    pa = '{-5000, -6000, -7000, -8000};
    pb = '{-9000, -9500, -9900, -9990};
    push(0, 1, 10, 4'b1111, 4'b1111);
    pa = '{-6000, -5500, -7000, -8000};
    pb = '{-100, -9500, -9900, -9990};
    push(0, 2, 10, 4'b1111, 4'b1111);
    rd(10, 1, "R5 larger replaces smaller kept");
    pa = '{-5000, 0, 0, 0};
    pb = '{-100, 0, 0, 0};
    push(0, 3, 10, 4'b0001, 4'b0001);
    rd(10, 1, "R5 equal value no change");
    rd(3, 5, "R5 other position untouched");
  endtask

  // R7, R8
  task automatic t_sat();
    pa = '{4000000, 0, 0, 0};
    pb = '{-4000000, 0, 0, 0};
    push(0, 1, 12, 4'b0001, 4'b0001);
    rd(12, 0, "R7 positive clamp");
    pa = '{-4000000, 0, 0, 0};
    pb = '{4000000, 0, 0, 0};
    push(0, 1, 13, 4'b0001, 4'b0001);
    rd(13, 0, "R7 negative clamp");
    pa = '{100, 0, 0, 0};
    pb = '{0, 0, 0, 0};
    push(0, 1, 14, 4'b0001, 4'b0000);
    rd(14, 200, "R8 bit-1 empty gives max");
    pa = '{0, 0, 0, 0};
    pb = '{100, 0, 0, 0};
    push(0, 1, 15, 4'b0000, 4'b0001);
    rd(15, -200, "R8 bit-0 empty gives min");
    rd(16, 255, "R8 both empty gives zero");
  endtask

  // R2
  task automatic t_sov();
    push(1, 0, 0, 4'b0000, 4'b0000);
    rd(3, 5, "R2 cleared pos 3");
    rd(12, 0, "R2 cleared pos 12");
    pa = '{-300, 0, 0, 0};
    pb = '{-900, 0, 0, 0};
    push(0, 1, 20, 4'b0001, 4'b0001);
    pa = '{-800, 0, 0, 0};
    pb = '{-1200, 0, 0, 0};
    push(1, 1, 20, 4'b0001, 4'b0001);
    rd(20, 0, "R2 same-cycle write into fresh state");
  endtask

  // R9
  task automatic t_latency();
    longint e_old;
    longint held;
    pa = '{640, 0, 0, 0};
    pb = '{-64, 0, 0, 0};
    @(negedge clk);
    e_old      = exp_llr(7, 0);
    apply_in(0, 1, 7, 4'b0001, 4'b0001);
    rd_en_i    = 1'b1;
    rd_idx_i   = IW'(7);
    rd_prior_i = '0;
    @(negedge clk);
    idle_in();
    rd_en_i = 1'b0;
    chk("R9 read same edge vld", longint'(llr_vld_o), 1);
    chk("R9 read sees old state", longint'(llr_o), e_old);
    rd(7, 0, "R9 next read sees write");
    held = longint'(llr_o);
    @(negedge clk);
    chk("R9 vld drops", longint'(llr_vld_o), 0);
    chk("R9 output held", longint'(llr_o), held);
  endtask

  initial begin
    rst_n      = 1'b0;
    sov_i      = 1'b0;
    samp_idx_i = '0;
    bit_idx_i  = '0;
    vld0_i     = '0;
    vld1_i     = '0;
    met0_i     = '0;
    met1_i     = '0;
    rd_en_i    = 1'b0;
    rd_idx_i   = '0;
    rd_prior_i = '0;
    for (int g = 0; g < 2; g++)
      for (int e = 0; e < NB; e++) begin
        mt[g][e] = 0;
        mm[g][e] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_tokens();
    t_burn();
    t_running();
    t_sat();
    t_sov();
    t_latency();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule